// File: doc/BRIEF.md
# Switching Waveform Parameter Extractor

This block reduces one switching period of reconstructed samples to three raw figures of merit for a power transistor under test. Each sample carries a gate voltage code, a drain voltage code, a drain current code, a gate-drive flag and its position in the period. The samples arrive in ascending position order, so arrival order and index order are the same.

From one period the block produces three results:
- The gate time constant, counted in equivalent-time steps. It runs from the start of the gate rise to the point where the gate first reaches 63% of its swing.
- The sums of drain voltage and drain current, and the number of samples that went into them. These cover only the samples taken while the gate drive was on. Software later divides these to get an on-resistance. The measurement is normally run with the drive on for 90% of the period.
- The gate code at the moment the drain current first reaches a programmed constant-current level. This level is usually set to about a hundred times the current measurement uncertainty.

The drain sums and the current-level crossing are found while the samples stream in. The time constant needs the gate minimum and maximum of the whole period, so the gate codes are stored. After the last sample, a scan walks the stored codes to find the time constant. A one-cycle done strobe then presents all results. The producer must wait for done before it starts the next period.

Top module: `sw_param_extract`

## Requirements
- R1: After synchronous reset, done, tau_ok and vth_ok are 0, and every result output is 0.
- R2: sum_drain_v and sum_drain_i are the sums of the drain voltage and drain current codes of the samples whose in_drive flag is 1. on_count is the number of those samples.
- R3: Samples with in_drive at 0 add nothing to either sum or to on_count. A period with the drive low throughout reports zero sums and a zero count.
- R4: vth_code is the gate code of the first sample, in arrival order, whose drain current code is greater than or equal to cfg_cc_level. Equality counts as a crossing. vth_ok is then 1.
- R5: If no sample of the period reaches cfg_cc_level, vth_ok is 0 and vth_code is 0.
- R6: The rise start is the lowest index whose gate code is strictly greater than the period's minimum gate code plus cfg_rise_delta.
- R7: The 63% level is min + (((max - min) * 161) >> 8), where min and max are the minimum and maximum gate codes of the period. The crossing is the lowest index at or after the rise start whose gate code is greater than or equal to that level. tau_steps is the crossing index minus the rise-start index.
- R8: If there is no rise start, or no crossing after it, tau_ok is 0 and tau_steps is 0.
- R9: done is high for exactly one cycle per period, after the sample flagged in_last has been consumed. The results change only together with done and hold their values until the next done.
- R10: Each period is measured on its own. Minimum, maximum, sums, count and crossings restart after every done, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_index | input | IDX_W | Position of the sample in the period |
| in_last | input | 1 | Final sample of the period |
| in_gate | input | 16 | Gate voltage code |
| in_drain_v | input | 16 | Drain voltage code |
| in_drain_i | input | 16 | Drain current code |
| in_drive | input | 1 | Gate drive on for this sample |
| cfg_cc_level | input | 16 | Constant-current level for the threshold crossing |
| cfg_rise_delta | input | 16 | Margin above the minimum gate code that marks the rise start |
| done | output | 1 | One-cycle result strobe |
| tau_steps | output | IDX_W | Time constant in sample steps |
| tau_ok | output | 1 | Time constant is valid |
| vth_code | output | 16 | Gate code at the current-level crossing |
| vth_ok | output | 1 | Current-level crossing was found |
| sum_drain_v | output | 16+IDX_W | Sum of drain voltage codes during conduction |
| sum_drain_i | output | 16+IDX_W | Sum of drain current codes during conduction |
| on_count | output | IDX_W+1 | Number of conduction samples |

## Verification
The time-constant search is driven with several gate waveforms:
- A ramped rise of moderate slope, which separates the rise start from the 63% crossing.
- A period that fills the whole store.
- A flat gate, which has no rise.
- A single-step jump, where the rise start and the crossing fall on the same sample.
- A ramp whose first risen sample equals minimum plus delta exactly, which shows whether the comparison is strict.

The drain-current patterns are chosen to test the threshold crossing:
- A current that crosses the level at the first sample.
- A current that lands exactly on the level, which tests that equality counts.
- A current that never reaches the level.

The drive flag is tested at 90% duty and at zero duty, so that sample gating shows up in the sums and in the count. The periods run back to back without reset, so any value left over from the previous period corrupts the next result.

// File: rtl/swx_pkg.sv
package swx_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int LVL_NUM   = 161;
    localparam int LVL_SHIFT = 8;

    typedef logic [SAMPLE_W-1:0] code_t;

    typedef struct packed {
        code_t gate;
        code_t volt;
        code_t curr;
        logic  drive;
    } samp_t;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_RUN,
        SC_FIN
    } scan_e;

    // min plus 161/256 of the swing between min and max
    function automatic code_t level63(input code_t lo, input code_t hi);
        logic [31:0] prod;
        prod = 32'(hi - lo) * 32'(LVL_NUM);
        return lo + code_t'(prod >> LVL_SHIFT);
    endfunction

endpackage

// File: rtl/swx_accum.sv
module swx_accum
    import swx_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int SUM_W = SAMPLE_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  samp_t            in_samp,
    input  code_t            cc_level,
    output code_t            gmin,
    output code_t            gmax,
    output logic [SUM_W-1:0] sum_v,
    output logic [SUM_W-1:0] sum_i,
    output logic [IDX_W:0]   cnt,
    output logic             hit,
    output code_t            hit_gate
);

    logic first;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            first    <= 1'b1;
            gmin     <= '0;
            gmax     <= '0;
            sum_v    <= '0;
            sum_i    <= '0;
            cnt      <= '0;
            hit      <= 1'b0;
            hit_gate <= '0;
        end else if (in_valid) begin
            first <= 1'b0;
            if (first || in_samp.gate < gmin) gmin <= in_samp.gate;
            if (first || in_samp.gate > gmax) gmax <= in_samp.gate;
            if (in_samp.drive) begin
                sum_v <= sum_v + SUM_W'(in_samp.volt);
                sum_i <= sum_i + SUM_W'(in_samp.curr);
                cnt   <= cnt + 1'b1;
            end
            if (!hit && in_samp.curr >= cc_level) begin
                hit      <= 1'b1;
                hit_gate <= in_samp.gate;
            end
        end
    end

endmodule

// File: rtl/swx_store.sv
module swx_store
    import swx_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  code_t            wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output code_t            rd_data
);

    code_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/swx_scan.sv
module swx_scan
    import swx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] last_addr,
    input  code_t            gmin,
    input  code_t            gmax,
    input  code_t            delta,
    output logic [IDX_W-1:0] rd_addr,
    input  code_t            rd_gate,
    output logic             busy,
    output logic             finish,
    output logic             tau_ok,
    output logic [IDX_W-1:0] tau
);

    scan_e            state;
    logic [IDX_W-1:0] k;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] rise_i;
    logic [IDX_W-1:0] cross_i;
    logic             rise_f;
    logic             cross_f;
    code_t            lvl;
    logic             above;
    logic             reach;

    always_comb begin
        lvl   = level63(gmin, gmax);
        above = {1'b0, rd_gate} > ({1'b0, gmin} + {1'b0, delta});
        reach = rd_gate >= lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SC_IDLE;
            k       <= '0;
            last_q  <= '0;
            rise_i  <= '0;
            cross_i <= '0;
            rise_f  <= 1'b0;
            cross_f <= 1'b0;
        end else begin
            case (state)
                SC_IDLE: begin
                    if (start) begin
                        k       <= '0;
                        last_q  <= last_addr;
                        rise_f  <= 1'b0;
                        cross_f <= 1'b0;
                        rise_i  <= '0;
                        cross_i <= '0;
                        state   <= SC_RUN;
                    end
                end
                SC_RUN: begin
                    if (!rise_f && above) begin
                        rise_f <= 1'b1;
                        rise_i <= k;
                        if (reach) begin
                            cross_f <= 1'b1;
                            cross_i <= k;
                        end
                    end else if (rise_f && !cross_f && reach) begin
                        cross_f <= 1'b1;
                        cross_i <= k;
                    end
                    if (k == last_q) state <= SC_FIN;
                    else             k     <= k + 1'b1;
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    assign rd_addr = k;
    assign busy    = (state != SC_IDLE);
    assign finish  = (state == SC_FIN);
    assign tau_ok  = rise_f && cross_f;
    assign tau     = tau_ok ? (cross_i - rise_i) : '0;

endmodule

// File: rtl/sw_param_extract.sv
module sw_param_extract
    import swx_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int SUM_W = SAMPLE_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_index,
    input  logic             in_last,
    input  logic [15:0]      in_gate,
    input  logic [15:0]      in_drain_v,
    input  logic [15:0]      in_drain_i,
    input  logic             in_drive,
    input  logic [15:0]      cfg_cc_level,
    input  logic [15:0]      cfg_rise_delta,
    output logic             done,
    output logic [IDX_W-1:0] tau_steps,
    output logic             tau_ok,
    output logic [15:0]      vth_code,
    output logic             vth_ok,
    output logic [SUM_W-1:0] sum_drain_v,
    output logic [SUM_W-1:0] sum_drain_i,
    output logic [IDX_W:0]   on_count
);

    samp_t            samp;
    logic             busy;
    logic             take;
    logic             start;
    logic             finish;
    code_t            gmin, gmax, hit_gate, rd_gate;
    logic [SUM_W-1:0] acc_v, acc_i;
    logic [IDX_W:0]   acc_n;
    logic             hit;
    logic [IDX_W-1:0] rd_addr;
    logic             sc_ok;
    logic [IDX_W-1:0] sc_tau;

    always_comb begin
        samp.gate  = in_gate;
        samp.volt  = in_drain_v;
        samp.curr  = in_drain_i;
        samp.drive = in_drive;
        take       = in_valid && !busy;
        start      = take && in_last;
    end

    swx_accum #(.IDX_W(IDX_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (finish),
        .in_valid (take),
        .in_samp  (samp),
        .cc_level (cfg_cc_level),
        .gmin     (gmin),
        .gmax     (gmax),
        .sum_v    (acc_v),
        .sum_i    (acc_i),
        .cnt      (acc_n),
        .hit      (hit),
        .hit_gate (hit_gate)
    );

    swx_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (take),
        .wr_addr (in_index),
        .wr_data (in_gate),
        .rd_addr (rd_addr),
        .rd_data (rd_gate)
    );

    swx_scan #(.IDX_W(IDX_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .last_addr (in_index),
        .gmin      (gmin),
        .gmax      (gmax),
        .delta     (cfg_rise_delta),
        .rd_addr   (rd_addr),
        .rd_gate   (rd_gate),
        .busy      (busy),
        .finish    (finish),
        .tau_ok    (sc_ok),
        .tau       (sc_tau)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            tau_steps   <= '0;
            tau_ok      <= 1'b0;
            vth_code    <= '0;
            vth_ok      <= 1'b0;
            sum_drain_v <= '0;
            sum_drain_i <= '0;
            on_count    <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                tau_steps   <= sc_tau;
                tau_ok      <= sc_ok;
                vth_code    <= hit ? hit_gate : '0;
                vth_ok      <= hit;
                sum_drain_v <= acc_v;
                sum_drain_i <= acc_i;
                on_count    <= acc_n;
            end
        end
    end

endmodule

// File: rtl/swx_checker.sv
module swx_checker #(
    parameter int IDX_W = 6,
    localparam int SUM_W = 16 + IDX_W
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic [IDX_W-1:0] tau_steps,
    input logic             tau_ok,
    input logic [15:0]      vth_code,
    input logic             vth_ok,
    input logic [SUM_W-1:0] sum_drain_v,
    input logic [SUM_W-1:0] sum_drain_i,
    input logic [IDX_W:0]   on_count
);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_sum_v_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sum_drain_v) |-> done);

    p_hold_tau_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(tau_steps) |-> done);

    p_tau_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !tau_ok |-> (tau_steps == '0));

    p_vth_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !vth_ok |-> (vth_code == '0));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        on_count <= (IDX_W + 1)'(1 << IDX_W));

    p_empty_sums_r3: assert property (@(posedge clk) disable iff (rst)
        (on_count == '0) |-> (sum_drain_v == '0 && sum_drain_i == '0));

endmodule

bind sw_param_extract swx_checker #(.IDX_W(IDX_W)) u_swx_checker (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .tau_steps   (tau_steps),
    .tau_ok      (tau_ok),
    .vth_code    (vth_code),
    .vth_ok      (vth_ok),
    .sum_drain_v (sum_drain_v),
    .sum_drain_i (sum_drain_i),
    .on_count    (on_count)
);

// File: tb/sw_param_extract_test.sv
module sw_param_extract_test;

    localparam int IDX_W = 6;
    localparam int SUM_W = 16 + IDX_W;
    localparam int KNEE  = 20000;

    typedef struct packed {
        int n;
        int base;
        int top;
        int rise_at;
        int step;
        int delta;
        int cc;
        int on_len;
    } case_t;

    localparam int NCASE = 7;
    localparam case_t CASES [NCASE] = '{
        '{40, 1000, 40000,  5,  3000,  200, 20000, 36},
        '{64,  500, 60000, 10,  1500,  100,   100, 57},
        '{20, 30000, 30000, 0,     0,   10,  5000, 18},
        '{32, 2000, 30000,  3,  8000,   50, 65535,  0},
        '{16,    0, 50000,  2, 60000, 1000,     1, 14},
        '{20, 30000, 30000, 0,     0,   10, 40000, 18},
        '{30, 1000, 30000,  4,   200,  200, 60000, 27}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [IDX_W-1:0] in_index;
    logic             in_last;
    logic [15:0]      in_gate, in_drain_v, in_drain_i;
    logic             in_drive;
    logic [15:0]      cfg_cc_level, cfg_rise_delta;
    logic             done;
    logic [IDX_W-1:0] tau_steps;
    logic             tau_ok;
    logic [15:0]      vth_code;
    logic             vth_ok;
    logic [SUM_W-1:0] sum_drain_v, sum_drain_i;
    logic [IDX_W:0]   on_count;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    int g [64];
    int v [64];
    int c [64];
    int d [64];

    int e_sv, e_si, e_cnt, e_vth, e_vok, e_tau, e_tok;

    always #5 clk = ~clk;

    sw_param_extract #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index),
        .in_last(in_last), .in_gate(in_gate), .in_drain_v(in_drain_v),
        .in_drain_i(in_drain_i), .in_drive(in_drive),
        .cfg_cc_level(cfg_cc_level), .cfg_rise_delta(cfg_rise_delta),
        .done(done), .tau_steps(tau_steps), .tau_ok(tau_ok),
        .vth_code(vth_code), .vth_ok(vth_ok), .sum_drain_v(sum_drain_v),
        .sum_drain_i(sum_drain_i), .on_count(on_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input case_t cs);
        for (int i = 0; i < 64; i++) begin
            int gv;
            if (i < cs.rise_at) gv = cs.base;
            else begin
                gv = cs.base + (i - cs.rise_at + 1) * cs.step;
                if (gv > cs.top) gv = cs.top;
            end
            g[i] = gv;
            c[i] = (gv > KNEE) ? (gv - KNEE) * 4 : 0;
            if (c[i] > 65535) c[i] = 65535;
            d[i] = (i < cs.on_len) ? 1 : 0;
            v[i] = d[i] != 0 ? 200 + 7 * i : 50000;
        end
    endtask

    task automatic model(input case_t cs);
        int mn, mx, lvl, r;
        mn = g[0]; mx = g[0];
        e_sv = 0; e_si = 0; e_cnt = 0; e_vth = 0; e_vok = 0;
        e_tau = 0; e_tok = 0; r = -1;
        for (int i = 0; i < cs.n; i++) begin
            if (g[i] < mn) mn = g[i];
            if (g[i] > mx) mx = g[i];
            if (d[i] != 0) begin
                e_sv += v[i]; e_si += c[i]; e_cnt++;
            end
            if (e_vok == 0 && c[i] >= cs.cc) begin
                e_vok = 1; e_vth = g[i];
            end
        end
        lvl = mn + (((mx - mn) * 161) >>> 8);
        for (int i = 0; i < cs.n; i++) begin
            if (r < 0 && g[i] > mn + cs.delta) r = i;
            if (r >= 0 && e_tok == 0 && g[i] >= lvl) begin
                e_tok = 1; e_tau = i - r;
            end
        end
    endtask

    task automatic run_period(input case_t cs);
        int wd;
        cfg_cc_level   = 16'(cs.cc);
        cfg_rise_delta = 16'(cs.delta);
        for (int i = 0; i < cs.n; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_index   = IDX_W'(i);
            in_last    = (i == cs.n - 1);
            in_gate    = 16'(g[i]);
            in_drain_v = 16'(v[i]);
            in_drain_i = 16'(c[i]);
            in_drive   = d[i][0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        wd = 0;
        while (!done && wd < 500) begin
            @(negedge clk);
            wd++;
        end
        chk("R9 done seen", done, 1);
    endtask

    task automatic check_results(input int idx);
        string s;
        s = $sformatf(" case %0d", idx);
        chk({"R2 sum_drain_v", s}, sum_drain_v, e_sv);
        chk({"R2 sum_drain_i", s}, sum_drain_i, e_si);
        chk({"R3 on_count", s}, on_count, e_cnt);
        chk({"R4 vth_ok", s}, vth_ok, e_vok);
        chk({"R5 vth_code", s}, vth_code, e_vth);
        chk({"R7 tau_steps", s}, tau_steps, e_tau);
        chk({"R8 tau_ok", s}, tau_ok, e_tok);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 0; in_index = '0; in_last = 0; in_gate = '0;
        in_drain_v = '0; in_drain_i = '0; in_drive = 0;
        cfg_cc_level = '0; cfg_rise_delta = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 tau_ok", tau_ok, 0);
        chk("R1 vth_ok", vth_ok, 0);
        chk("R1 sum_drain_v", sum_drain_v, 0);
        chk("R1 on_count", on_count, 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk; periods back to back without reset (R10)
        for (int k = 0; k < NCASE; k++) begin
            build(CASES[k]);
            model(CASES[k]);
            run_period(CASES[k]);
            check_results(k);
            @(negedge clk);
            chk("R9 done single cycle", done, 0);
        end

        // R6: case 6 has its first risen sample at exactly min+delta
        chk("R6 strict rise start tau", tau_steps, e_tau);

        // R9: results hold while idle
        repeat (6) @(negedge clk);
        chk("R9 hold tau", tau_steps, e_tau);
        chk("R9 hold sum_drain_i", sum_drain_i, e_si);

        // R10: repeat case 0 after the others, no reset in between
        build(CASES[0]);
        model(CASES[0]);
        run_period(CASES[0]);
        chk("R10 fresh sum_drain_v", sum_drain_v, e_sv);
        chk("R10 fresh tau", tau_steps, e_tau);
        chk("R10 fresh vth", vth_code, e_vth);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule